// File: doc/BRIEF.md
# Load/Store Addressing-Mode Timing Sequencer

This block sits in the issue stage of a pipeline. It takes one decoded single-transfer memory operation (load, store or preload) and turns it into pipeline timing. From the addressing form it works out how many issue cycles the operation needs. While the extra issue cycles run, it holds the issue slot with a busy flag. It then raises a one-cycle strobe when the loaded value is ready and another when the updated base register is ready.

Offset forms split into two classes. Fast forms issue in one cycle. Slow forms are pre-indexed register offsets that are subtracted or use an uncommon shift, and they need three. An operation flagged as possibly unaligned needs a second memory beat, which adds one cycle to the issue count and to both latencies. Address generation, the memory access and register-file writes are handled elsewhere; this block only supplies the cycle timing.

Top module: `lsu_addr_timing_seq`

Cycle numbering: the cycle in which `req_valid` and `req_ready` are both high is cycle 0, and cycle k is the k-th cycle after it. N is the issue-cycle count of the accepted operation.

## Requirements
- R1: `req_ready` is the inverse of `busy`. A request is never accepted while `busy` is high, and a request held at the input is accepted in the first cycle that `busy` is low.
- R2: A post-indexed operation (`req_post_idx`=1) is fast whatever its offset kind, sign or shift, so N=1 when it is aligned and `busy` stays low in cycle 1.
- R3: A pre-indexed operation is fast when it uses an immediate offset (`req_reg_off`=0). It is also fast when it adds a register offset that is unshifted or shifted left by 1 to 3, where the shift type code is 2'b00 (left) and the amount is 0 to 3.
- R4: A pre-indexed register-offset operation is slow when the offset is subtracted (`req_neg_off`=1), or when the shift type is 2'b01, 2'b10 or 2'b11, or when the left-shift amount is 4 or more. An aligned slow operation has N=3.
- R5: `req_unaligned`=1 adds one issue cycle, so fast becomes N=2 and slow becomes N=4. `busy` is high in cycles 1 to N-1 and low in cycle N.
- R6: For a load (`req_load`=1), `data_ready` is high only in cycle N+1. This gives 2, 4, 3 or 5 for aligned fast, aligned slow, unaligned fast and unaligned slow.
- R7: With `req_wback`=1, `base_ready` is high only in cycle N. This gives 1, 3, 2 or 4 for the same four cases.
- R8: A store or preload (`req_load`=0) never produces a `data_ready` pulse.
- R9: With `req_wback`=0, the operation never produces a `base_ready` pulse.
- R10: When a second request is accepted in the first cycle after the first one's issue cycles, both requests' strobes appear at their own latencies, and neither suppresses the other.
- R11: While `rst_n` is low, `busy`, `data_ready` and `base_ready` are low at each clock edge, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Descriptor present |
| req_ready | output | 1 | Descriptor accepted this cycle if valid |
| req_load | input | 1 | 1 = load returning data, 0 = store or preload |
| req_post_idx | input | 1 | 1 = post-indexed, 0 = pre-indexed |
| req_reg_off | input | 1 | 1 = register offset, 0 = immediate |
| req_neg_off | input | 1 | 1 = offset subtracted |
| req_shift_type | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 rotate |
| req_shift_amt | input | 5 | Shift amount applied to the register offset |
| req_wback | input | 1 | Base register is updated |
| req_unaligned | input | 1 | Access may be unaligned (two memory beats) |
| busy | output | 1 | Extra issue cycles in progress |
| data_ready | output | 1 | One-cycle strobe: load value available |
| base_ready | output | 1 | One-cycle strobe: updated base available |

## Verification
The classifier is driven with post-indexed forms that carry negative offsets and rotate shifts. Any fast or slow verdict on those must come from the indexing bit alone. Pre-indexed forms sweep the shift amount across the 3-to-4 boundary and try each non-left shift type, which separates the fast and slow classes at their exact edges. Each class is repeated with the unaligned flag set, which shows whether the extra cycle also moves both strobes. Loads, stores and preloads with and without writeback show whether the two strobes are gated independently. A held request behind a slow operation shows whether acceptance waits for `busy` and whether strobes from overlapping operations both survive.

// File: rtl/lsu_tm_pkg.sv
// Package: shared constants and types for the load/store timing sequencer.
// Assumes the issue counts of the two address classes are fixed at build time;
// every width below is derived from them.
package lsu_tm_pkg;

    localparam int SHAMT_W      = 5;  // shift amount field width
    localparam int ISSUE_FAST   = 1;  // issue cycles for fast offset forms
    localparam int ISSUE_SLOW   = 3;  // issue cycles for slow offset forms
    localparam int UNAL_EXTRA   = 1;  // extra cycles for a second memory beat
    localparam int FAST_LSL_MAX = 3;  // largest left shift that stays fast

    localparam int MAX_ISSUE = ISSUE_SLOW + UNAL_EXTRA;
    localparam int MAX_LAT   = MAX_ISSUE + 1;
    localparam int ISS_W     = $clog2(MAX_ISSUE + 1);
    localparam int CNT_W     = $clog2(MAX_ISSUE);
    localparam int LAT_W     = $clog2(MAX_LAT + 1);

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_e;

    typedef struct packed {
        logic                is_load;
        logic                post_idx;
        logic                reg_off;
        logic                neg_off;
        shift_e              sh_type;
        logic [SHAMT_W-1:0]  sh_amt;
        logic                wback;
        logic                unaligned;
    } ls_desc_t;

endpackage

// File: rtl/lsu_mode_classify.sv
// Module: lsu_mode_classify
// Maps a decoded load/store descriptor to its issue-cycle count.
// Purely combinational; assumes the descriptor is stable while valid.
module lsu_mode_classify
    import lsu_tm_pkg::*;
(
    input  ls_desc_t            desc,
    output logic                slow_form,
    output logic [ISS_W-1:0]    issue_cyc
);

    logic fast_shift;

    // Decide whether the offset shift is one the fast adder path supports.
    always_comb begin
        fast_shift = (desc.sh_type == SH_LSL) &&
                     (desc.sh_amt <= SHAMT_W'(FAST_LSL_MAX));
    end

    // Slow only for pre-indexed register offsets that subtract or shift oddly.
    always_comb begin
        slow_form = !desc.post_idx && desc.reg_off &&
                    (desc.neg_off || !fast_shift);
    end

    // Base cycles of the class plus the second memory beat when unaligned.
    always_comb begin
        issue_cyc = slow_form ? ISS_W'(ISSUE_SLOW) : ISS_W'(ISSUE_FAST);
        if (desc.unaligned) begin
            issue_cyc = issue_cyc + ISS_W'(UNAL_EXTRA);
        end
    end

endmodule

// File: rtl/lsu_issue_counter.sv
// Module: lsu_issue_counter
// Holds busy for issue_cyc-1 cycles after an accepted request.
// Assumes accept only occurs while busy is low (enforced by the top).
module lsu_issue_counter
    import lsu_tm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic [ISS_W-1:0]    issue_cyc,
    output logic                busy
);

    logic [CNT_W-1:0] remain;

    // Load the remaining issue cycles on accept, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (accept) begin
            remain <= CNT_W'(issue_cyc - ISS_W'(1));
        end else if (remain != '0) begin
            remain <= remain - CNT_W'(1);
        end
    end

    // Busy while extra issue cycles remain.
    always_comb begin
        busy = (remain != '0);
    end

    AST_NO_ACCEPT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !accept); // R1

    AST_BUSY_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(accept)); // R1

    AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && issue_cyc == ISS_W'(MAX_ISSUE)) |=> busy ##1 busy ##1 busy ##1 !busy); // R5

endmodule

// File: rtl/lsu_pulse_sched.sv
// Module: lsu_pulse_sched
// Schedules a one-cycle pulse DELAY cycles after fire, with several in flight.
// Assumes 1 <= delay <= DEPTH whenever fire is high.
module lsu_pulse_sched
    import lsu_tm_pkg::*;
#(
    parameter int DEPTH = MAX_LAT,
    localparam int DW   = $clog2(DEPTH + 1)
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  logic [DW-1:0]   delay,
    output logic            pulse
);

    logic [DEPTH-1:0] slot;
    logic [DEPTH-1:0] slot_nxt;

    // Each slot takes the one above it, plus a new entry at its own delay.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        if (i == DEPTH - 1) begin : g_top
            always_comb slot_nxt[i] = fire && (delay == DW'(i + 1));
        end else begin : g_mid
            always_comb slot_nxt[i] = slot[i+1] || (fire && (delay == DW'(i + 1)));
        end
    end

    // Advance the slot line every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= '0;
        end else begin
            slot <= slot_nxt;
        end
    end

    // The bottom slot is the strobe.
    always_comb begin
        pulse = slot[0];
    end

    AST_DELAY_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (delay >= DW'(1) && delay <= DW'(DEPTH))); // R6

    AST_ONE_CYCLE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && delay == DW'(1)) |=> pulse); // R7

endmodule

// File: rtl/lsu_addr_timing_seq.sv
// Module: lsu_addr_timing_seq (top)
// Accepts one load/store descriptor at a time, holds busy for its extra issue
// cycles and strobes data_ready / base_ready at the class latencies.
// Assumes descriptor fields are valid whenever req_valid is high.
module lsu_addr_timing_seq
    import lsu_tm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_load,
    input  logic                req_post_idx,
    input  logic                req_reg_off,
    input  logic                req_neg_off,
    input  logic [1:0]          req_shift_type,
    input  logic [SHAMT_W-1:0]  req_shift_amt,
    input  logic                req_wback,
    input  logic                req_unaligned,
    output logic                busy,
    output logic                data_ready,
    output logic                base_ready
);

    ls_desc_t           desc;
    logic               slow_form;
    logic [ISS_W-1:0]   issue_cyc;
    logic               accept;
    logic [LAT_W-1:0]   data_lat;
    logic [LAT_W-1:0]   base_lat;

    // Gather the port fields into one descriptor.
    always_comb begin
        desc.is_load   = req_load;
        desc.post_idx  = req_post_idx;
        desc.reg_off   = req_reg_off;
        desc.neg_off   = req_neg_off;
        desc.sh_type   = shift_e'(req_shift_type);
        desc.sh_amt    = req_shift_amt;
        desc.wback     = req_wback;
        desc.unaligned = req_unaligned;
    end

    lsu_mode_classify u_classify (
        .desc      (desc),
        .slow_form (slow_form),
        .issue_cyc (issue_cyc)
    );

    // Handshake: ready whenever no issue cycles are outstanding.
    always_comb begin
        req_ready = !busy;
        accept    = req_valid && req_ready;
    end

    // Base is ready as issue ends; data one cycle later.
    always_comb begin
        base_lat = LAT_W'(issue_cyc);
        data_lat = LAT_W'(issue_cyc) + LAT_W'(1);
    end

    lsu_issue_counter u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .issue_cyc (issue_cyc),
        .busy      (busy)
    );

    lsu_pulse_sched #(.DEPTH(MAX_LAT)) u_data_sched (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (accept && req_load),
        .delay (data_lat),
        .pulse (data_ready)
    );

    lsu_pulse_sched #(.DEPTH(MAX_LAT)) u_base_sched (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (accept && req_wback),
        .delay (base_lat),
        .pulse (base_ready)
    );

    AST_POST_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_post_idx && !req_unaligned) |=> !busy); // R2

    AST_PRE_IMM_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_post_idx && !req_reg_off && !req_unaligned) |=> !busy); // R3

    AST_NEG_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_post_idx && req_reg_off && req_neg_off && !req_unaligned)
        |=> busy ##1 busy ##1 !busy); // R4

    AST_SLOW_FLAG_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && slow_form) |=> busy); // R4

    AST_LOAD_DATA_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_load && req_post_idx && !req_unaligned) |=> ##1 data_ready); // R6

    AST_NO_DATA_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_load && req_post_idx && !req_unaligned) |=> ##1 !data_ready); // R8

    AST_NO_BASE_NOWB: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_wback && req_post_idx && !req_unaligned) |=> !base_ready); // R9

endmodule

// File: tb/lsu_addr_timing_seq_tb_top.sv
// Directed bench: each task drives one scenario and checks its own strobes.
module lsu_addr_timing_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 20000;

    typedef struct packed {
        logic       load;
        logic       post;
        logic       regoff;
        logic       neg;
        logic [1:0] sht;
        logic [4:0] amt;
        logic       wb;
        logic       unal;
    } req_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_load = 1'b0;
    logic       req_post_idx = 1'b0;
    logic       req_reg_off = 1'b0;
    logic       req_neg_off = 1'b0;
    logic [1:0] req_shift_type = 2'b00;
    logic [4:0] req_shift_amt = '0;
    logic       req_wback = 1'b0;
    logic       req_unaligned = 1'b0;
    logic       busy;
    logic       data_ready;
    logic       base_ready;

    int  n_total = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_addr_timing_seq dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_load       (req_load),
        .req_post_idx   (req_post_idx),
        .req_reg_off    (req_reg_off),
        .req_neg_off    (req_neg_off),
        .req_shift_type (req_shift_type),
        .req_shift_amt  (req_shift_amt),
        .req_wback      (req_wback),
        .req_unaligned  (req_unaligned),
        .busy           (busy),
        .data_ready     (data_ready),
        .base_ready     (base_ready)
    );

    // Issue count from the requirement rules.
    function automatic int ref_issue(input req_t r);
        int n;
        n = (!r.post && r.regoff && (r.neg || r.sht != 2'b00 || r.amt > 5'd3)) ? 3 : 1;
        if (r.unal) n = n + 1;
        return n;
    endfunction

    function automatic req_t mk(input bit load, input bit post, input bit regoff,
                                input bit neg, input bit [1:0] sht, input int amt,
                                input bit wb, input bit unal);
        req_t r;
        r.load = load; r.post = post; r.regoff = regoff; r.neg = neg;
        r.sht = sht; r.amt = 5'(amt); r.wb = wb; r.unal = unal;
        return r;
    endfunction

    task automatic chk(input bit got, input bit exp, input string what, input int cyc);
        n_total++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %b expected %b", what, cyc, got, exp);
        end
    endtask

    task automatic drive(input req_t r);
        req_load       = r.load;
        req_post_idx   = r.post;
        req_reg_off    = r.regoff;
        req_neg_off    = r.neg;
        req_shift_type = r.sht;
        req_shift_amt  = r.amt;
        req_wback      = r.wb;
        req_unaligned  = r.unal;
    endtask

    // Drive request a (and optionally b held behind it) and check every cycle.
    task automatic run_seq(input req_t a, input bit has_b, input req_t b, input string tag);
        bit [15:0] eb = '0;
        bit [15:0] ed = '0;
        bit [15:0] ebs = '0;
        int na = ref_issue(a);
        int nb = ref_issue(b);
        int accb = na;
        for (int k = 1; k < na; k++) eb[k] = 1'b1;
        if (a.load) ed[na+1] = 1'b1;
        if (a.wb)   ebs[na]  = 1'b1;
        if (has_b) begin
            for (int k = 1; k < nb; k++) eb[accb+k] = 1'b1;
            if (b.load) ed[accb+nb+1] = 1'b1;
            if (b.wb)   ebs[accb+nb]  = 1'b1;
        end
        @(negedge clk);
        drive(a);
        req_valid = 1'b1;
        chk(req_ready, 1'b1, {tag, " R1 ready at request"}, 0);
        for (int c = 1; c <= 12; c++) begin
            @(negedge clk);
            if (c == 1) begin
                if (has_b) drive(b);
                else req_valid = 1'b0;
            end
            if (has_b && c == accb + 1) req_valid = 1'b0;
            chk(busy,       eb[c],  {tag, " busy"}, c);
            chk(req_ready, !eb[c],  {tag, " R1 req_ready"}, c);
            chk(data_ready, ed[c],  {tag, " R6 data_ready"}, c);
            chk(base_ready, ebs[c], {tag, " R7 base_ready"}, c);
        end
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        repeat (2) @(negedge clk);
        chk(busy,       1'b0, "R11 busy in reset", 0);
        chk(data_ready, 1'b0, "R11 data_ready in reset", 0);
        chk(base_ready, 1'b0, "R11 base_ready in reset", 0);
        chk(req_ready,  1'b1, "R11 req_ready in reset", 0);
        rst_n = 1'b1;
    endtask

    task automatic t_post_forms;
        run_seq(mk(1, 1, 0, 0, 2'b00, 0, 1, 0), 0, '0, "R2 post imm");
        run_seq(mk(1, 1, 1, 1, 2'b11, 7, 1, 0), 0, '0, "R2 post neg ror");
        run_seq(mk(1, 1, 1, 0, 2'b01, 9, 1, 0), 0, '0, "R2 post lsr");
    endtask

    task automatic t_pre_fast;
        run_seq(mk(1, 0, 0, 1, 2'b00, 0, 1, 0), 0, '0, "R3 pre imm");
        run_seq(mk(1, 0, 1, 0, 2'b00, 0, 1, 0), 0, '0, "R3 pre reg plain");
        run_seq(mk(1, 0, 1, 0, 2'b00, 3, 1, 0), 0, '0, "R3 pre reg lsl3");
    endtask

    task automatic t_pre_slow;
        run_seq(mk(1, 0, 1, 1, 2'b00, 0, 1, 0), 0, '0, "R4 pre reg neg");
        run_seq(mk(1, 0, 1, 0, 2'b00, 4, 1, 0), 0, '0, "R4 pre reg lsl4");
        run_seq(mk(1, 0, 1, 0, 2'b01, 1, 1, 0), 0, '0, "R4 pre reg lsr");
        run_seq(mk(1, 0, 1, 0, 2'b10, 2, 1, 0), 0, '0, "R4 pre reg asr");
        run_seq(mk(1, 0, 1, 0, 2'b11, 3, 1, 0), 0, '0, "R4 pre reg ror");
    endtask

    task automatic t_unaligned;
        run_seq(mk(1, 1, 0, 0, 2'b00, 0, 1, 1), 0, '0, "R5 unal fast");
        run_seq(mk(1, 0, 1, 1, 2'b10, 5, 1, 1), 0, '0, "R5 unal slow");
    endtask

    task automatic t_store_preload;
        run_seq(mk(0, 1, 0, 0, 2'b00, 0, 1, 0), 0, '0, "R8 store fast");
        run_seq(mk(0, 0, 1, 1, 2'b00, 0, 1, 1), 0, '0, "R8 store slow unal");
        run_seq(mk(0, 0, 0, 0, 2'b00, 0, 0, 0), 0, '0, "R8 preload");
    endtask

    task automatic t_no_wback;
        run_seq(mk(1, 0, 0, 0, 2'b00, 0, 0, 0), 0, '0, "R9 load no wb");
        run_seq(mk(1, 0, 1, 0, 2'b01, 2, 0, 1), 0, '0, "R9 slow no wb");
    endtask

    task automatic t_back_to_back;
        run_seq(mk(1, 0, 1, 1, 2'b00, 0, 1, 0), 1, mk(1, 1, 0, 0, 2'b00, 0, 1, 0), "R10 slow then fast");
        run_seq(mk(1, 1, 0, 0, 2'b00, 0, 1, 0), 1, mk(1, 1, 0, 0, 2'b00, 0, 1, 1), "R10 fast then unal");
        run_seq(mk(1, 0, 1, 0, 2'b11, 1, 1, 1), 1, mk(0, 0, 1, 0, 2'b00, 2, 1, 0), "R10 held behind R1 busy");
    endtask

    initial begin
        t_reset();
        t_post_forms();
        t_pre_fast();
        t_pre_slow();
        t_unaligned();
        t_store_preload();
        t_no_wback();
        t_back_to_back();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYC);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule